// File: doc/BRIEF.md
# Sectioned lookahead adder

This block adds two 32-bit operands and an incoming carry in pure combinational logic. The word is cut into four equal sections of eight bits. Each section works out all of its internal carries at once from per-bit generate and propagate terms, written as flat AND-OR expressions. The carry leaving one section enters the next, from the least significant section to the most significant.

Besides the 32-bit sum and the final carry-out, the block exposes the carry entering the top bit position. A consumer that treats the operands as two's-complement values can XOR that carry with the carry-out to form a signed overflow flag without repeating any of the addition. A parameter selects whether the propagate term is the OR or the XOR of the operand bits; both must give identical results.

Top module: `cla_adder32`

## Requirements
- R1: `sum_o` equals `a_i + b_i + cin_i` modulo 2^32 for every input combination.
- R2: `cout_o` equals bit 32 of the full 33-bit sum of `a_i`, `b_i` and `cin_i`.
- R3: `c31_o` is the carry entering bit 31, so that `c31_o ^ cout_o` is 1 exactly when the two's-complement sum of the operands does not fit in 32 bits.
- R4: A carry generated at the top bit of one section is seen by the bit just above it in the next section, e.g. `0x80 + 0x80` gives `0x100`.
- R5: An incoming carry travels through sections that are all-propagate: `0xFFFFFFFF + 0 + 1` gives sum 0 and `cout_o` 1.
- R6: Bit pairs that are both 0 stop a carry: `0x0000FF00 + 0x0000FF00` with no incoming carry gives `0x0001FE00`, and a carry-in of 1 alone into zero operands gives sum 1 and `cout_o` 0.
- R7: With all inputs zero the outputs are all zero.
- R8: The OR-propagate variant (`PROP_XOR` = 0) and the XOR-propagate variant (`PROP_XOR` = 1) produce identical `sum_o`, `cout_o` and `c31_o` for the same inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 32 | Sum modulo 2^32 |
| cout_o | output | 1 | Carry out of bit 31 |
| c31_o | output | 1 | Carry into bit 31 |

## Verification
Immediate assertions in each section compare its eight sum bits and carry-out with an arithmetic add whenever the inputs change, and the top level checks the whole sum, the carry-out and the relation between the carry into bit 31 and the top sum bit. Whether long carry chains cross every section boundary, and whether the two propagate variants agree, is shown only by the bench, which drives directed chain patterns and a seeded random stream into both variants side by side and compares every output against its own arithmetic model.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned GROUP_W_DEF    = 8;
  localparam int unsigned NUM_GROUPS_DEF = 4;
endpackage

// File: rtl/cla_pg_cell.sv
module cla_pg_cell #(
  parameter bit PROP_XOR = 1'b0
) (
  input  logic a_i,
  input  logic b_i,
  output logic gen_o,
  output logic prop_o,
  output logic half_o
);
  assign gen_o  = a_i & b_i;
  assign half_o = a_i ^ b_i;

  generate
    if (PROP_XOR) begin : g_prop_xor
      assign prop_o = a_i ^ b_i;
    end else begin : g_prop_or
      assign prop_o = a_i | b_i;
    end
  endgenerate
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int unsigned W        = 8,
  parameter bit          PROP_XOR = 1'b0
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cbit_o,
  output logic         cout_o
);
  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W-1:0] half;
  logic [W:0]   carry;

  assign carry[0] = cin_i;

  generate
    for (genvar k = 0; k < W; k++) begin : g_cell
      cla_pg_cell #(.PROP_XOR(PROP_XOR)) i_cell (
        .a_i   (a_i[k]),
        .b_i   (b_i[k]),
        .gen_o (gen[k]),
        .prop_o(prop[k]),
        .half_o(half[k])
      );
    end

    // Flat lookahead: carry into bit i+1 is an OR of product terms,
    // each one a generate at bit j masked by propagates above it.
    for (genvar i = 0; i < W; i++) begin : g_carry
      logic [i+1:0] term;
      for (genvar j = 0; j <= i; j++) begin : g_term
        if (j == i) begin : g_top
          assign term[j] = gen[j];
        end else begin : g_mid
          assign term[j] = gen[j] & (&prop[i:j+1]);
        end
      end
      assign term[i+1] = cin_i & (&prop[i:0]);
      assign carry[i+1] = |term;
    end
  endgenerate

  assign sum_o  = half ^ carry[W-1:0];
  assign cbit_o = carry[W-1:0];
  assign cout_o = carry[W];

  logic [W:0] ref_sum;
  assign ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};

  always_comb begin
    assert_group_sum_R1: assert (sum_o == ref_sum[W-1:0]);
    assert_group_cout_R2: assert (cout_o == ref_sum[W]);
  end
endmodule

// File: rtl/cla_adder32.sv
module cla_adder32 #(
  parameter int unsigned GROUP_W    = cla_pkg::GROUP_W_DEF,
  parameter int unsigned NUM_GROUPS = cla_pkg::NUM_GROUPS_DEF,
  parameter bit          PROP_XOR   = 1'b0
) (
  input  logic [GROUP_W*NUM_GROUPS-1:0] a_i,
  input  logic [GROUP_W*NUM_GROUPS-1:0] b_i,
  input  logic                          cin_i,
  output logic [GROUP_W*NUM_GROUPS-1:0] sum_o,
  output logic                          cout_o,
  output logic                          c31_o
);
  localparam int unsigned WIDTH = GROUP_W * NUM_GROUPS;

  logic [NUM_GROUPS:0] link;
  logic [WIDTH-1:0]    cbit;

  assign link[0] = cin_i;

  generate
    for (genvar s = 0; s < NUM_GROUPS; s++) begin : g_sect
      cla_group #(.W(GROUP_W), .PROP_XOR(PROP_XOR)) i_group (
        .a_i   (a_i[s*GROUP_W +: GROUP_W]),
        .b_i   (b_i[s*GROUP_W +: GROUP_W]),
        .cin_i (link[s]),
        .sum_o (sum_o[s*GROUP_W +: GROUP_W]),
        .cbit_o(cbit[s*GROUP_W +: GROUP_W]),
        .cout_o(link[s+1])
      );
    end
  endgenerate

  assign cout_o = link[NUM_GROUPS];
  assign c31_o  = cbit[WIDTH-1];

  logic [WIDTH:0] full_ref;
  assign full_ref = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  always_comb begin
    assert_total_sum_R1: assert (sum_o == full_ref[WIDTH-1:0]);
    assert_total_cout_R2: assert (cout_o == full_ref[WIDTH]);
    assert_top_carry_R3: assert ((a_i[WIDTH-1] ^ b_i[WIDTH-1] ^ c31_o) == sum_o[WIDTH-1]);
  end
endmodule

// File: tb/test_cla_adder32.sv
module test_cla_adder32;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] a, b;
  logic        cin;
  logic [31:0] sum_o, sum_x;
  logic        cout_o, cout_x, c31_o, c31_x;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  cla_adder32 i_cla_adder32 (
    .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum_o), .cout_o(cout_o), .c31_o(c31_o)
  );

  cla_adder32 #(.PROP_XOR(1'b1)) i_cla_adder32_x (
    .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum_x), .cout_o(cout_x), .c31_o(c31_x)
  );

  function automatic logic [32:0] model_sum(logic [31:0] x, logic [31:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {32'd0, c};
  endfunction

  function automatic logic model_c31(logic [31:0] x, logic [31:0] y, logic c);
    logic [31:0] low;
    low = {1'b0, x[30:0]} + {1'b0, y[30:0]} + {31'd0, c};
    return low[31];
  endfunction

  function automatic logic model_ovf(logic [31:0] x, logic [31:0] y, logic c);
    longint sx, sy, t;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    t  = sx + sy + longint'(c);
    return (t > 64'sd2147483647) || (t < -64'sd2147483648);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h cin=%0d actual=%h expected=%h", req, a, b, cin, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] x, logic [31:0] y, logic c, string tag);
    logic [32:0] e;
    @(negedge clk);
    a = x; b = y; cin = c;
    #2;
    e = model_sum(x, y, c);
    check({tag, " R1 sum"},  {32'd0, sum_o},  {32'd0, e[31:0]});
    check({tag, " R2 cout"}, {63'd0, cout_o}, {63'd0, e[32]});
    check({tag, " R3 c31"},  {63'd0, c31_o},  {63'd0, model_c31(x, y, c)});
    check({tag, " R3 ovf"},  {63'd0, c31_o ^ cout_o}, {63'd0, model_ovf(x, y, c)});
    check({tag, " R8 variant"}, {sum_x, 29'd0, cout_x, c31_x, 1'b0},
                                {sum_o, 29'd0, cout_o, c31_o, 1'b0});
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    #2;
    check("R7 zero inputs sum", {32'd0, sum_o}, 64'd0);
    check("R7 zero inputs carries", {62'd0, cout_o, c31_o}, 64'd0);

    apply(32'h0000_0080, 32'h0000_0080, 1'b0, "R4 boundary 7->8");
    check("R4 sum 0x100", {32'd0, sum_o}, 64'h100);
    apply(32'h0080_0000, 32'h0080_0000, 1'b0, "R4 boundary 23->24");
    apply(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "R5 full chain");
    check("R5 sum zero", {32'd0, sum_o}, 64'd0);
    check("R5 carry out", {63'd0, cout_o}, 64'd1);
    apply(32'h0000_FF00, 32'h0000_FF00, 1'b0, "R6 kill");
    check("R6 sum", {32'd0, sum_o}, 64'h0001_FE00);
    apply(32'h0000_0000, 32'h0000_0000, 1'b1, "R6 cin only");
    check("R6 cin only sum", {32'd0, sum_o}, 64'd1);
    apply(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, "R3 pos overflow");
    apply(32'h8000_0000, 32'h8000_0000, 1'b0, "R3 neg overflow");
    apply(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, "R3 mixed signs");
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R2 all ones");
    apply(32'h00FF_00FF, 32'h0000_FF01, 1'b0, "R4 alternating sections");

    process::self().srandom(32'd1357);
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] x, y;
      x = $urandom;
      y = $urandom;
      if (n % 4 == 1) y = ~x;
      if (n % 8 == 3) x = x | 32'hFF00_FF00;
      apply(x, y, 1'($urandom), "R1 random");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule